// File: doc/BRIEF.md
# Comparator Event Timer

A register-mapped timer block with one 64-bit free-running up-counter and three comparator channels, reached through a simple 32-bit single-cycle read/write bus. Software reads a capability word to learn the counter width, the tick period in femtoseconds and how many channels exist. It then programs each channel with a match value, and optionally a period, and starts the counter through the global configuration register.

When the advancing counter equals a channel's comparator, the channel raises its interrupt. A one-shot channel fires and keeps its comparator. A periodic channel adds its stored period to the comparator so that it fires again one period later. Each channel drives its own interrupt line, either as a one-cycle pulse (edge mode) or as a level held until software clears the status bit. Channel 0 supports periodic mode and a 64-bit comparator. Channels 1 and 2 are 32-bit and one-shot only.

Reads are combinational from the address. Writes take effect at the next rising clock edge.

Top module: `evt_timer`

## Requirements
- R1: Offset 0x000 reads a capability word: bits 7:0 hold the revision, bits 12:8 hold the index of the last channel (2), bit 13 is 1 (64-bit counter), bit 15 is the legacy-route capability (0), and bits 31:16 hold the vendor value. With the default parameters the word is 0xA5C32201. Offset 0x004 reads the tick period in femtoseconds (default 0x00989680).
- R2: After a synchronous reset the following are zero: the global configuration, the counter, the status register, all channel configurations and all comparators. All interrupt lines are low.
- R3: Global configuration at 0x010: bit 0 is the run bit and bit 1 is a stored route bit. The counter rises by exactly one per clock while bit 0 is set and holds its value while bit 0 is clear.
- R4: The counter is written in 32-bit halves at 0x0F0 (low) and 0x0F4 (high). A counter write takes priority over that cycle's increment.
- R5: Channel n configuration sits at 0x100+0x20*n. The bits are: 1 = level mode, 2 = interrupt enable, 3 = periodic, 4 = periodic capable (read-only), 5 = 64-bit comparator (read-only), 6 = value-set, 8 = 32-bit mode, 13:9 = route. On channels 1 and 2, bits 3 and 6 read 0 and ignore writes, and channel 0 reads 0x30 after reset.
- R6: A channel matches when the counter is advancing and equals its comparator. With interrupts enabled, the match sets status bit n at 0x020. With interrupts disabled it sets nothing. A one-shot match leaves the comparator unchanged.
- R7: In edge mode the interrupt line is high for exactly one cycle, starting at the same edge that sets the status bit.
- R8: In level mode the interrupt line follows the status bit while interrupts are enabled. Writing 1 to status bit n clears it, and writing 0 leaves it unchanged.
- R9: On a match in periodic mode, the comparator increases by the stored period.
- R10: While the value-set bit is 1 in periodic mode, a write to either comparator half (+0x08 low, +0x0C high) loads that half of both the comparator and the period. Any comparator write clears the value-set bit. Without the value-set bit, only the comparator changes.
- R11: On 32-bit channels, writes to the upper comparator half are ignored and that half reads 0.
- R12: Channels 1 and 2, and channel 0 with bit 8 set, compare only the low 32 bits of the counter. Channel 0 without bit 8 compares all 64 bits.
- R13: If a status clear and a new match land on the same edge, the status bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 3 | Per-channel interrupt lines |

## Verification
Two events can land on the same edge: the counter reaching a comparator, and a software write that touches the same state. The first collision is a status clear against a fresh match. The bench writes the counter to three below the comparator and waits three idle edges, so that its write of 1 to the status bit lands exactly on the match edge; the bit must read back set. The second collision is a counter write against the running increment. The bench writes the counter while the run bit is on and reads it back before the next edge, expecting the written value with no increment added.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int CNT_W  = 64;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_CAP     = 12'h000;
    localparam logic [ADDR_W-1:0] A_PERIOD  = 12'h004;
    localparam logic [ADDR_W-1:0] A_GCFG    = 12'h010;
    localparam logic [ADDR_W-1:0] A_STATUS  = 12'h020;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 12'h0F0;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 12'h0F4;
    localparam logic [ADDR_W-1:0] A_CH_BASE = 12'h100;
    localparam int               CH_SHIFT  = 5;
    localparam logic [4:0]       O_CFG     = 5'h00;
    localparam logic [4:0]       O_CMP_LO  = 5'h08;
    localparam logic [4:0]       O_CMP_HI  = 5'h0C;

    typedef struct packed {
        logic [4:0] route;
        logic       narrow;
        logic       valset;
        logic       periodic;
        logic       ien;
        logic       level;
    } ch_cfg_t;

    function automatic logic [DATA_W-1:0] cap_word(
        input logic [7:0]  rev,
        input logic [15:0] vendor,
        input int          nch,
        input logic        legacy);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[7:0]   = rev;
        w[12:8]  = 5'(nch - 1);
        w[13]    = 1'b1;
        w[15]    = legacy;
        w[31:16] = vendor;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_word(
        input ch_cfg_t c, input logic cap_per, input logic cap64);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[1]     = c.level;
        w[2]     = c.ien;
        w[3]     = c.periodic;
        w[4]     = cap_per;
        w[5]     = cap64;
        w[6]     = c.valset;
        w[8]     = c.narrow;
        w[13:9]  = c.route;
        return w;
    endfunction
endpackage

// File: rtl/evt_counter.sv
module evt_counter
    import evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic              adv
);
    assign adv = run && !wr_lo && !wr_hi;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (wr_lo)
            cnt[31:0] <= wdata;
        else if (wr_hi)
            cnt[63:32] <= wdata;
        else if (run)
            cnt <= cnt + 1'b1;
    end

    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (run && !wr_lo && !wr_hi) |=> (cnt == $past(cnt) + 64'd1));
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_lo && !wr_hi) |=> (cnt == $past(cnt)));
    a_r4_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (cnt[31:0] == $past(wdata)));
endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_pkg::*;
#(
    parameter bit CAP64  = 1'b0,
    parameter bit CAPPER = 1'b0
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              cnt_adv,
    input  logic              cfg_we,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic              sts_clr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg_rd,
    output logic [CNT_W-1:0]  cmp_rd,
    output logic              sts,
    output logic              irq
);
    ch_cfg_t          cfg;
    logic [CNT_W-1:0] cmp, per;
    logic             pulse, wide, hit, load_per;

    assign wide     = CAP64 && !cfg.narrow;
    assign hit      = cnt_adv && (wide ? (cnt == cmp) : (cnt[31:0] == cmp[31:0]));
    assign load_per = cfg.valset && cfg.periodic;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            cmp <= '0;
            per <= '0;
        end else if (cfg_we) begin
            cfg.level    <= wdata[1];
            cfg.ien      <= wdata[2];
            cfg.periodic <= CAPPER ? wdata[3] : 1'b0;
            cfg.valset   <= CAPPER ? wdata[6] : 1'b0;
            cfg.narrow   <= wdata[8];
            cfg.route    <= wdata[13:9];
        end else if (lo_we) begin
            cmp[31:0]  <= wdata;
            if (load_per) per[31:0] <= wdata;
            cfg.valset <= 1'b0;
        end else if (hi_we) begin
            if (CAP64) begin
                cmp[63:32] <= wdata;
                if (load_per) per[63:32] <= wdata;
            end
            cfg.valset <= 1'b0;
        end else if (hit && cfg.periodic) begin
            if (wide) cmp <= cmp + per;
            else      cmp[31:0] <= cmp[31:0] + per[31:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts   <= 1'b0;
            pulse <= 1'b0;
        end else begin
            if (hit && cfg.ien)  sts <= 1'b1;
            else if (sts_clr)    sts <= 1'b0;
            pulse <= hit && cfg.ien && !cfg.level;
        end
    end

    assign irq    = cfg.level ? (sts && cfg.ien) : pulse;
    assign cfg_rd = cfg_word(cfg, CAPPER, CAP64);
    assign cmp_rd = cmp;

    a_r7_pulse_flags: assert property (@(posedge clk) disable iff (rst)
        (irq && !cfg.level) |-> sts);
    a_r8_level_holds: assert property (@(posedge clk) disable iff (rst)
        (cfg.level && irq && !sts_clr && !cfg_we) |=> irq);
    a_r9_reload: assert property (@(posedge clk) disable iff (rst)
        (hit && cfg.periodic && !cfg_we && !lo_we && !hi_we)
        |=> (cmp[31:0] == $past(cmp[31:0] + per[31:0])));
    a_r10_valset_drop: assert property (@(posedge clk) disable iff (rst)
        (lo_we || hi_we) |=> !cfg.valset);
    a_r13_set_wins: assert property (@(posedge clk) disable iff (rst)
        (hit && cfg.ien) |=> sts);
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_pkg::*;
#(
    parameter int          NCH        = 3,
    parameter logic [7:0]  REV        = 8'h01,
    parameter logic [15:0] VENDOR     = 16'hA5C3,
    parameter logic [31:0] PERIOD_FS  = 32'h0098_9680,
    parameter bit          LEGACY_CAP = 1'b0
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NCH-1:0]      irq
);
    localparam int               SLOT_W  = ADDR_W - CH_SHIFT;
    localparam logic [SLOT_W-1:0] SLOT0  = SLOT_W'(A_CH_BASE >> CH_SHIFT);

    logic                  wr;
    logic                  run, route_sel;
    logic [CNT_W-1:0]      cnt;
    logic                  adv;
    logic [NCH-1:0]        sts;
    logic [DATA_W-1:0]     cfg_rd [NCH];
    logic [CNT_W-1:0]      cmp_rd [NCH];

    assign wr = bus_sel && bus_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            run       <= 1'b0;
            route_sel <= 1'b0;
        end else if (wr && bus_addr == A_GCFG) begin
            run       <= bus_wdata[0];
            route_sel <= bus_wdata[1];
        end
    end

    evt_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .wr_lo (wr && bus_addr == A_CNT_LO),
        .wr_hi (wr && bus_addr == A_CNT_HI),
        .wdata (bus_wdata),
        .cnt   (cnt),
        .adv   (adv)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit_slot;
        assign hit_slot = wr && (bus_addr[ADDR_W-1:CH_SHIFT] == SLOT0 + SLOT_W'(i));
        evt_channel #(
            .CAP64  (i == 0),
            .CAPPER (i == 0)
        ) u_ch (
            .clk     (clk),
            .rst     (rst),
            .cnt     (cnt),
            .cnt_adv (adv),
            .cfg_we  (hit_slot && bus_addr[4:0] == O_CFG),
            .lo_we   (hit_slot && bus_addr[4:0] == O_CMP_LO),
            .hi_we   (hit_slot && bus_addr[4:0] == O_CMP_HI),
            .sts_clr (wr && bus_addr == A_STATUS && bus_wdata[i]),
            .wdata   (bus_wdata),
            .cfg_rd  (cfg_rd[i]),
            .cmp_rd  (cmp_rd[i]),
            .sts     (sts[i]),
            .irq     (irq[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CAP:    bus_rdata = cap_word(REV, VENDOR, NCH, LEGACY_CAP);
            A_PERIOD: bus_rdata = PERIOD_FS;
            A_GCFG:   bus_rdata = {30'b0, route_sel, run};
            A_STATUS: bus_rdata = DATA_W'(sts);
            A_CNT_LO: bus_rdata = cnt[31:0];
            A_CNT_HI: bus_rdata = cnt[63:32];
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (bus_addr[ADDR_W-1:CH_SHIFT] == SLOT0 + SLOT_W'(i)) begin
                        case (bus_addr[4:0])
                            O_CFG:    bus_rdata = cfg_rd[i];
                            O_CMP_LO: bus_rdata = cmp_rd[i][31:0];
                            O_CMP_HI: bus_rdata = cmp_rd[i][63:32];
                            default:  bus_rdata = '0;
                        endcase
                    end
                end
            end
        endcase
    end

    a_r2_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (irq == '0 && sts == '0));
endmodule

// File: tb/sim_evt_timer.sv
module sim_evt_timer;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int checks = 0;
    int fails  = 0;
    int hits [3];
    logic done = 1'b0;

    evt_timer u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_NS/2) clk = ~clk;

    always @(negedge clk)
        for (int k = 0; k < 3; k++) if (irq[k]) hits[k]++;

    function automatic logic [11:0] ch_a(input int n, input int off);
        return 12'(32'h100 + 32'h20 * n + off);
    endfunction

    function automatic logic [31:0] exp_cap();
        return {16'hA5C3, 1'b0, 1'b0, 1'b1, 5'd2, 8'h01};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        for (int k = 0; k < 3; k++) hits[k] = 0;
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, a, b;
        void'($urandom(32'd2718));
        do_reset();

        // R1 / R2 reset view
        rd(12'h000, d); chk("R1 cap", d, exp_cap());
        rd(12'h004, d); chk("R1 period", d, 32'h0098_9680);
        rd(12'h010, d); chk("R2 gcfg", d, 0);
        rd(12'h0F0, d); chk("R2 cnt lo", d, 0);
        rd(12'h020, d); chk("R2 status", d, 0);
        rd(ch_a(0, 0), d); chk("R5 ch0 cfg reset", d, 32'h30);
        rd(ch_a(1, 0), d); chk("R2 ch1 cfg", d, 0);
        rd(ch_a(2, 8), d); chk("R2 ch2 cmp", d, 0);
        chk("R2 irq", {61'b0, irq}, 0);

        // R3 stopped counter, R4 halves
        idle(5);
        rd(12'h0F0, d); chk("R3 hold while off", d, 0);
        wr(12'h0F0, 32'h0000_0100);
        wr(12'h0F4, 32'h0000_0001);
        rd(12'h0F0, a); rd(12'h0F4, b);
        chk("R4 halves", {b, a}, 64'h1_0000_0100);
        wr(12'h010, 32'h3);
        rd(12'h010, d); chk("R3 gcfg readback", d, 3);
        rd(12'h0F0, a); idle(10); rd(12'h0F0, b);
        chk("R3 step count", b - a, 10);
        wr(12'h0F0, 32'h50);
        rd(12'h0F0, d); chk("R4 write beats increment", d, 32'h50);

        // R5 / R11 channel capability handling
        do_reset();
        wr(ch_a(1, 0), 32'h4C);
        rd(ch_a(1, 0), d); chk("R5 ch1 drops periodic/valset", d, 32'h04);
        wr(ch_a(1, 12), 32'hFFFF);
        rd(ch_a(1, 12), d); chk("R11 ch1 upper ignored", d, 0);
        wr(ch_a(0, 12), 32'h1234);
        rd(ch_a(0, 12), d); chk("R11 ch0 upper kept", d, 32'h1234);

        // R6 / R7 random one-shot edge on channel 1
        for (int it = 0; it < 8; it++) begin
            int c;
            c = $urandom_range(3, 60);
            do_reset();
            wr(ch_a(1, 0), 32'h04);
            wr(ch_a(1, 8), 32'(c));
            wr(12'h010, 32'h1);
            idle(c); #2;
            chk("R7 no early pulse", hits[1], 0);
            idle(2); #2;
            chk("R7 single pulse", hits[1], 1);
            rd(12'h020, d); chk("R6 status set", d, 32'h2);
            rd(ch_a(1, 8), d); chk("R6 one-shot keeps cmp", d, 32'(c));
        end

        // R8 level on ch2, R6 disabled ch1
        do_reset();
        wr(ch_a(2, 0), 32'h06); wr(ch_a(2, 8), 5);
        wr(ch_a(1, 0), 32'h00); wr(ch_a(1, 8), 5);
        wr(12'h010, 32'h1);
        idle(10); #2;
        chk("R8 level high", {63'b0, irq[2]}, 1);
        chk("R6 disabled ch no pulse", hits[1], 0);
        rd(12'h020, d); chk("R6 disabled ch no status", d, 32'h4);
        wr(12'h020, 32'h0); #2;
        chk("R8 write 0 no effect", {63'b0, irq[2]}, 1);
        wr(12'h020, 32'h4); #2;
        chk("R8 w1c drops line", {63'b0, irq[2]}, 0);
        rd(12'h020, d); chk("R8 status cleared", d, 0);

        // R9 / R10 periodic ch0
        do_reset();
        wr(ch_a(0, 0), 32'h4C);
        wr(ch_a(0, 8), 7);
        rd(ch_a(0, 0), d); chk("R10 valset cleared", d, 32'h3C);
        wr(12'h010, 32'h1);
        idle(23); #2;
        chk("R9 three periodic pulses", hits[0], 3);
        rd(ch_a(0, 8), d); chk("R9 cmp advanced", d, 28);
        wr(ch_a(0, 8), 100);
        idle(10);
        rd(ch_a(0, 8), d); chk("R10 plain write cmp only", d, 100);

        // R12 narrow compare on ch0
        do_reset();
        wr(12'h0F4, 32'h5);
        wr(ch_a(0, 0), 32'h104); wr(ch_a(0, 8), 10);
        wr(12'h010, 32'h1);
        idle(13); #2;
        chk("R12 narrow matches low half", hits[0], 1);
        do_reset();
        wr(12'h0F4, 32'h5);
        wr(ch_a(0, 0), 32'h004); wr(ch_a(0, 8), 10);
        wr(12'h010, 32'h1);
        idle(13); #2;
        chk("R12 wide needs upper half", hits[0], 0);

        // R13 clear and match on same edge
        do_reset();
        wr(ch_a(2, 0), 32'h06); wr(ch_a(2, 8), 40);
        wr(12'h010, 32'h1);
        wr(12'h0F0, 37);
        idle(3);
        wr(12'h020, 32'h4);
        rd(12'h020, d); chk("R13 set wins", d, 32'h4);
        chk("R13 line high", {63'b0, irq[2]}, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule